// File: doc/BRIEF.md
# Threshold-Managed Packet Transmit FIFO

A single-clock buffer that holds frames of 32-bit words on their way from a streaming user source to a MAC transmitter. Each stored word carries its data, a start-of-frame flag, an end-of-frame flag and a count of unused trailing bytes. Four threshold values, taken from configuration inputs, shape its behaviour. The start level decides when the read side may begin a frame: cut-through once enough words are stored, or store-and-forward when the value is zero. The headroom value decides when the writer loses ready. The two warning levels report how much room remains and whether the store is running dry.

The read side presents the head word with a valid/ready handshake. A count of stored frame ends tells the read side at all times whether the frame being sent can be completed. If the store drains below the low-water mark while no frame end is held, the block does not stall the transmitter. It emits a closing beat marked with an error, pulses an underflow output, and then silently drops the rest of the broken frame as the writer delivers it.

Top module: `pkt_tx_fifo`

## Requirements
- R1: After reset the read side shows no valid beat, write ready is high, almost-full is low, the low-water flag is high, the room warning is high and the underflow output is low.
- R2: Words leave in the order they were written, with data, start flag, end flag and the 2-bit unused-byte count unchanged, and the error flag low.
- R3: Write ready is low and almost-full is high exactly when free space (depth minus stored words) is at or below the headroom threshold; with default settings, a writer that never reads in fills the store with depth minus 3 words.
- R4: With a non-zero start threshold N, a frame with no end stored becomes readable one cycle after the N-th word is stored, and not before.
- R5: With the start threshold at 0, no beat is offered until the frame's end word is stored, whatever the fill level.
- R6: The room warning output is high while the stored count is at or below the room threshold and low once it rises above it.
- R7: The low-water flag is high while the stored count is below the low-water threshold.
- R8: When a frame is being read, no frame end is stored and the stored count is below the low-water threshold, the next beat offered has data 0, end flag 1 and error flag 1; the underflow output is high for exactly the one cycle in which that beat is accepted.
- R9: After such an abort, every remaining word of the broken frame, up to and including its end word, is dropped without being offered; the next frame is delivered whole.
- R10: The thresholds are taken from the configuration inputs only while the store is empty and no frame is in progress; changes at other times have no effect.
- R11: The store never accepts a word when full, and a beat held without ready keeps its valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sec_full_i | input | 9 | Start threshold in words; 0 selects store-and-forward |
| cfg_sec_empty_i | input | 9 | Room warning threshold in words |
| cfg_alm_full_i | input | 9 | Headroom threshold in free words |
| cfg_alm_empty_i | input | 9 | Low-water threshold in words |
| wr_valid_i | input | 1 | Writer offers a word |
| wr_ready_o | output | 1 | Store accepts a word |
| wr_data_i | input | 32 | Word data |
| wr_sop_i | input | 1 | First word of a frame |
| wr_eop_i | input | 1 | Last word of a frame |
| wr_empty_i | input | 2 | Unused bytes in the last word |
| rd_valid_o | output | 1 | Beat offered to the transmitter |
| rd_ready_i | input | 1 | Transmitter takes the beat |
| rd_data_o | output | 32 | Beat data |
| rd_sop_o | output | 1 | First beat of a frame |
| rd_eop_o | output | 1 | Last beat of a frame |
| rd_empty_o | output | 2 | Unused bytes in the last beat |
| rd_err_o | output | 1 | Frame closed by underflow |
| alm_full_o | output | 1 | Free space at or below headroom threshold |
| alm_empty_o | output | 1 | Stored count below low-water threshold |
| sec_empty_o | output | 1 | Stored count at or below room threshold |
| underflow_o | output | 1 | One-cycle pulse when an abort beat is accepted |

## Verification
A frame whose end arrives after the start level is reached tells cut-through apart from store-and-forward: the first beat must appear at the start level in one mode and only after the end word in the other. Filling without reading until ready drops shows the headroom rule and crosses both warning levels, while a headroom change made mid-fill shows that thresholds stay frozen. Draining that unfinished frame past the low-water mark separates a clean end from an abort, and a short frame written after the broken one's tail shows whether the tail was dropped and normal delivery resumed.

// File: rtl/pkt_tx_fifo_pkg.sv
package pkt_tx_fifo_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SEND  = 2'd1,
    RD_ABORT = 2'd2,
    RD_DROP  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/ptf_store.sv
module ptf_store #(
  parameter int W     = 36,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ptf_occupancy.sv
module ptf_occupancy #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_eop_i,
  input  logic          pop_i,
  input  logic          pop_eop_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] eop_cnt_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q, eops_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      eops_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + AW'(1);
      if (pop_i)  rptr_q <= rptr_q + AW'(1);
      level_q <= level_q + LW'(push_i) - LW'(pop_i);
      eops_q  <= eops_q + LW'(push_i && push_eop_i) - LW'(pop_i && pop_eop_i);
    end
  end

  assign waddr_o   = wptr_q;
  assign raddr_o   = rptr_q;
  assign level_o   = level_q;
  assign eop_cnt_o = eops_q;
endmodule

// File: rtl/ptf_thresh.sv
module ptf_thresh #(
  parameter int LW        = 9,
  parameter int DEF_SFULL = 16,
  parameter int DEF_SEMPT = 240,
  parameter int DEF_AFULL = 3,
  parameter int DEF_AEMPT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] sfull_i,
  input  logic [LW-1:0] sempt_i,
  input  logic [LW-1:0] afull_i,
  input  logic [LW-1:0] aempt_i,
  output logic [LW-1:0] sfull_o,
  output logic [LW-1:0] sempt_o,
  output logic [LW-1:0] afull_o,
  output logic [LW-1:0] aempt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sfull_o <= LW'(DEF_SFULL);
      sempt_o <= LW'(DEF_SEMPT);
      afull_o <= LW'(DEF_AFULL);
      aempt_o <= LW'(DEF_AEMPT);
    end else if (load_i) begin
      sfull_o <= sfull_i;
      sempt_o <= sempt_i;
      afull_o <= afull_i;
      aempt_o <= aempt_i;
    end
  end
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
  import pkt_tx_fifo_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int EMPTY_W       = 2,
  parameter int DEPTH         = 256,
  parameter int DEF_SEC_FULL  = 16,
  parameter int DEF_SEC_EMPTY = DEPTH - 16,
  parameter int DEF_ALM_FULL  = 3,
  parameter int DEF_ALM_EMPTY = 8,
  localparam int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   cfg_sec_full_i,
  input  logic [LVL_W-1:0]   cfg_sec_empty_i,
  input  logic [LVL_W-1:0]   cfg_alm_full_i,
  input  logic [LVL_W-1:0]   cfg_alm_empty_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               wr_sop_i,
  input  logic               wr_eop_i,
  input  logic [EMPTY_W-1:0] wr_empty_i,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_sop_o,
  output logic               rd_eop_o,
  output logic [EMPTY_W-1:0] rd_empty_o,
  output logic               rd_err_o,
  output logic               alm_full_o,
  output logic               alm_empty_o,
  output logic               sec_empty_o,
  output logic               underflow_o
);
  localparam int AW     = $clog2(DEPTH);
  localparam int BEAT_W = DATA_W + EMPTY_W + 2;

  rd_state_e state_q, state_d;

  logic [AW-1:0]     waddr, raddr;
  logic [LVL_W-1:0]  level, eop_cnt, free;
  logic [LVL_W-1:0]  th_sec_full, th_sec_empty, th_alm_full, th_alm_empty;
  logic [BEAT_W-1:0] head;
  logic              head_sop, head_eop;
  logic [EMPTY_W-1:0] head_empty;
  logic [DATA_W-1:0] head_data;
  logic              push, pop, starve, send_ok, cfg_load, start_ok;

  // head word: {sop, eop, empty, data}
  assign {head_sop, head_eop, head_empty, head_data} = head;

  assign free        = LVL_W'(DEPTH) - level;
  assign alm_full_o  = free <= th_alm_full;
  assign wr_ready_o  = !alm_full_o;
  assign alm_empty_o = level < th_alm_empty;
  assign sec_empty_o = level <= th_sec_empty;

  assign push     = wr_valid_i && wr_ready_o;
  assign starve   = (eop_cnt == '0) && (level < th_alm_empty);
  assign send_ok  = (state_q == RD_SEND) && (level != '0) && !starve;
  assign pop      = (send_ok && rd_ready_i) || ((state_q == RD_DROP) && (level != '0));
  assign cfg_load = (state_q == RD_IDLE) && (level == '0);
  assign start_ok = (level != '0) &&
                    ((eop_cnt != '0) || ((th_sec_full != '0) && (level >= th_sec_full)));

  assign rd_valid_o  = send_ok || (state_q == RD_ABORT);
  assign rd_data_o   = (state_q == RD_SEND) ? head_data : '0;
  assign rd_sop_o    = (state_q == RD_SEND) && head_sop;
  assign rd_eop_o    = (state_q == RD_ABORT) || ((state_q == RD_SEND) && head_eop);
  assign rd_empty_o  = (state_q == RD_SEND) ? head_empty : '0;
  assign rd_err_o    = (state_q == RD_ABORT);
  assign underflow_o = (state_q == RD_ABORT) && rd_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE:  if (start_ok) state_d = RD_SEND;
      RD_SEND: begin
        if (starve)                state_d = RD_ABORT;
        else if (pop && head_eop)  state_d = RD_IDLE;
      end
      RD_ABORT: if (rd_ready_i) state_d = RD_DROP;
      RD_DROP:  if (pop && head_eop) state_d = RD_IDLE;
      default:  state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RD_IDLE;
    else         state_q <= state_d;
  end

  ptf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_eop_i (wr_eop_i),
    .pop_i      (pop),
    .pop_eop_i  (head_eop),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .level_o    (level),
    .eop_cnt_o  (eop_cnt)
  );

  ptf_store #(.W(BEAT_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (waddr),
    .wdata_i ({wr_sop_i, wr_eop_i, wr_empty_i, wr_data_i}),
    .raddr_i (raddr),
    .rdata_o (head)
  );

  ptf_thresh #(
    .LW        (LVL_W),
    .DEF_SFULL (DEF_SEC_FULL),
    .DEF_SEMPT (DEF_SEC_EMPTY),
    .DEF_AFULL (DEF_ALM_FULL),
    .DEF_AEMPT (DEF_ALM_EMPTY)
  ) u_thresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load),
    .sfull_i (cfg_sec_full_i),
    .sempt_i (cfg_sec_empty_i),
    .afull_i (cfg_alm_full_i),
    .aempt_i (cfg_alm_empty_i),
    .sfull_o (th_sec_full),
    .sempt_o (th_sec_empty),
    .afull_o (th_alm_full),
    .aempt_o (th_alm_empty)
  );
endmodule

// File: rtl/pkt_tx_fifo_chk.sv
module pkt_tx_fifo_chk #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_sop_o,
  input logic              rd_eop_o,
  input logic              rd_err_o,
  input logic              underflow_o,
  input logic [LVL_W-1:0]  level,
  input logic [LVL_W-1:0]  eop_cnt,
  input logic [LVL_W-1:0]  th_sec_full
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o |-> level < LVL_W'(DEPTH)); // R11
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_eop_o)); // R11
  AST_ABORT_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> rd_valid_o && rd_eop_o && rd_err_o && rd_data_o == '0); // R8
  AST_UFLOW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> !underflow_o); // R8
  AST_ERR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_err_o |-> rd_eop_o && !rd_sop_o); // R2
  AST_NO_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_err_o |-> level != '0); // R11
  AST_SAF_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_sop_o && th_sec_full == '0 |-> eop_cnt != '0); // R5
endmodule

bind pkt_tx_fifo pkt_tx_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rd_data_o   (rd_data_o),
  .rd_sop_o    (rd_sop_o),
  .rd_eop_o    (rd_eop_o),
  .rd_err_o    (rd_err_o),
  .underflow_o (underflow_o),
  .level       (level),
  .eop_cnt     (eop_cnt),
  .th_sec_full (th_sec_full)
);

// File: tb/pkt_tx_fifo_test.sv
`timescale 1ns/100ps
module pkt_tx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_sf = 9'd16, cfg_se = 9'd240, cfg_af = 9'd3, cfg_ae = 9'd8;
  logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_empty = '0;
  logic        rd_ready = 1'b0;
  logic        wr_ready, rd_valid, rd_sop, rd_eop, rd_err, alm_full, alm_empty, sec_empty, uflow;
  logic [31:0] rd_data;
  logic [1:0]  rd_empty;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pkt_tx_fifo uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_sec_full_i(cfg_sf), .cfg_sec_empty_i(cfg_se),
    .cfg_alm_full_i(cfg_af), .cfg_alm_empty_i(cfg_ae),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .wr_sop_i(wr_sop), .wr_eop_i(wr_eop), .wr_empty_i(wr_empty),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .rd_sop_o(rd_sop), .rd_eop_o(rd_eop), .rd_empty_o(rd_empty), .rd_err_o(rd_err),
    .alm_full_o(alm_full), .alm_empty_o(alm_empty), .sec_empty_o(sec_empty),
    .underflow_o(uflow)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_beat(input logic [31:0] d, input logic s, input logic e, input logic [1:0] em);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_empty = em;
    @(posedge clk);
    #1 wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_empty = '0;
  endtask

  task automatic rd_beat(output logic [31:0] d, output logic s, output logic e,
                         output logic er, output logic [1:0] em, output logic uf);
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
    rd_ready = 1'b1;
    #1;
    d = rd_data; s = rd_sop; e = rd_eop; er = rd_err; em = rd_empty; uf = uflow;
    @(posedge clk);
    #1 rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "wr_ready", wr_ready, 1);
    check("R1", "alm_full", alm_full, 0);
    check("R1", "alm_empty", alm_empty, 1);
    check("R1", "sec_empty", sec_empty, 1);
    check("R1", "underflow", uflow, 0);
  endtask

  task automatic t_cut_through();
    logic [31:0] d; logic s, e, er, uf; logic [1:0] em;
    for (int i = 1; i <= 15; i++) begin
      wr_beat(32'h100 + i, i == 1, 1'b0, 2'd0);
      @(negedge clk);
      if (i == 7) check("R7", "alm_empty at 7", alm_empty, 1);
      if (i == 8) check("R7", "alm_empty at 8", alm_empty, 0);
    end
    @(negedge clk);
    check("R4", "valid below start level", rd_valid, 0);
    wr_beat(32'h110, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    @(negedge clk);
    check("R4", "valid at start level", rd_valid, 1);
    check("R4", "sop at start", rd_sop, 1);
    for (int i = 17; i <= 20; i++) wr_beat(32'h100 + i, 1'b0, i == 20, (i == 20) ? 2'd2 : 2'd0);
    for (int i = 1; i <= 20; i++) begin
      rd_beat(d, s, e, er, em, uf);
      check("R2", "data", d, 32'h100 + i);
      check("R2", "sop", s, i == 1);
      check("R2", "eop", e, i == 20);
      check("R2", "empty", em, (i == 20) ? 2 : 0);
      check("R2", "err", er, 0);
    end
  endtask

  task automatic t_store_forward();
    logic [31:0] d; logic s, e, er, uf; logic [1:0] em;
    cfg_sf = 9'd0;
    repeat (2) @(negedge clk);
    for (int i = 1; i <= 20; i++) wr_beat(32'h200 + i, i == 1, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    check("R5", "valid without eop", rd_valid, 0);
    wr_beat(32'h215, 1'b0, 1'b1, 2'd1);
    @(negedge clk);
    @(negedge clk);
    check("R5", "valid after eop", rd_valid, 1);
    for (int i = 1; i <= 21; i++) begin
      rd_beat(d, s, e, er, em, uf);
      check("R5", "data", d, 32'h200 + i);
      if (i == 21) check("R5", "eop/empty", {e, em}, 3'b101);
    end
    cfg_sf = 9'd16;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_fill_abort();
    logic [31:0] d; logic s, e, er, uf; logic [1:0] em;
    int n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n == 240) check("R6", "sec_empty at 240", sec_empty, 1);
      if (n == 241) check("R6", "sec_empty at 241", sec_empty, 0);
      if (!wr_ready) break;
      wr_valid = 1'b1; wr_data = 32'h1000 + n; wr_sop = (n == 0);
      @(posedge clk);
      #1 wr_valid = 1'b0; wr_sop = 1'b0;
      n++;
      if (n == 1) cfg_af = 9'd50;
    end
    check("R3", "accepted words", n, 253);
    check("R10", "headroom frozen", n, 253);
    check("R3", "alm_full", alm_full, 1);
    cfg_af = 9'd3;
    for (int i = 0; i < 246; i++) begin
      rd_beat(d, s, e, er, em, uf);
      check("R8", "data before abort", d, 32'h1000 + i);
    end
    rd_beat(d, s, e, er, em, uf);
    check("R8", "abort data", d, 0);
    check("R8", "abort eop", e, 1);
    check("R8", "abort err", er, 1);
    check("R8", "underflow pulse", uf, 1);
    @(negedge clk);
    check("R8", "underflow one cycle", uflow, 0);
    for (int i = 0; i < 3; i++) wr_beat(32'h3000 + i, 1'b0, i == 2, 2'd0);
    repeat (4) @(negedge clk);
    check("R9", "tail dropped", rd_valid, 0);
    check("R9", "store empty", alm_empty, 1);
    for (int i = 0; i < 5; i++) wr_beat(32'h4000 + i, i == 0, i == 4, 2'd0);
    for (int i = 0; i < 5; i++) begin
      rd_beat(d, s, e, er, em, uf);
      check("R9", "next frame data", d, 32'h4000 + i);
      check("R9", "next frame flags", {s, e, er}, {i == 0, i == 4, 1'b0});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cut_through();
    t_store_forward();
    t_fill_abort();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule